// File: doc/BRIEF.md
# Per-Processor Device Interrupt Mask Router

This block sits between a set of device interrupt request lines and a small group of processors. It holds one shared vector of raw device requests and, for each processor, a mask register and a routed vector. A processor's routed vector is always its mask ANDed with the raw vector. Devices raise or drop one line at a time by pulsing a set or a clear strobe that carries a line index. Software loads a processor's mask through a plain write port.

The block reports every change in routing as an explicit event. For each processor it drives a post vector and a clear vector, with one bit per line. Each bit is a one-cycle pulse that appears in the cycle after the strobe or write that caused it. This lets the processor side track individual lines at the device interrupt level, which is level 1. The timer level (2) and the inter-processor level (3) are handled elsewhere.

Each processor also gets a registered level output that is high while anything is routed to it. Processors whose index is at or above the configured count are treated as absent. All inputs are plain strobes, accepted every cycle, and there is no back-pressure. No port exists that writes the raw or routed vectors directly.

Top module: `irq_route_top`

## Requirements
- R1: After reset, the raw vector, every mask, every routed vector, every event output and every level output read zero.
- R2: For every processor c, the routed vector read through the read port equals the mask of c ANDed with the raw vector, at all times.
- R3: A set strobe on line x sets raw bit x in the next cycle. In that same cycle, it pulses post bit x for every present processor whose mask has bit x set (after any same-cycle mask write), even when raw bit x was already set.
- R4: A clear strobe on line x whose raw bit is set clears raw bit x in the next cycle. It also pulses clear bit x for every processor whose routed vector had bit x set.
- R5: A clear strobe on a line whose raw bit is zero changes no raw bit, no mask and no routed bit, and it produces no event.
- R6: When set and clear strobes name the same line in the same cycle, the clear takes precedence and the set is dropped. No post event is produced for that line.
- R7: A mask write that changes bit x from 0 to 1, while raw bit x is set, pulses post bit x for that processor. A write that leaves an already-routed bit at 1 produces no event.
- R8: A mask write after which a previously routed bit x is no longer routed pulses clear bit x for that processor.
- R9: An event bit is a single-cycle pulse. Post and clear never pulse together for the same processor and line. A line whose routed state did not change gives no clear event.
- R10: For a processor index at or above NUM_CPUS, mask writes are ignored, its mask and routed vector read zero, and its event and level outputs stay zero.
- R11: The level output of processor c is high exactly when the routed vector of c is non-zero, with both sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_set_vld | input | 1 | Set strobe for one request line |
| dev_set_line | input | LINE_W | Line index of the set strobe |
| dev_clr_vld | input | 1 | Clear strobe for one request line |
| dev_clr_line | input | LINE_W | Line index of the clear strobe |
| msk_wr_en | input | 1 | Mask write strobe |
| msk_wr_cpu | input | CPU_W | Processor whose mask is written |
| msk_wr_data | input | LINES | New mask value |
| rd_cpu | input | CPU_W | Processor selected on the read port |
| rd_mask | output | LINES | Mask of the selected processor |
| rd_routed | output | LINES | Routed vector of the selected processor |
| raw_vec | output | LINES | Shared raw request vector |
| post_evt | output | MAX_CPUS*LINES | Post pulses, processor c at bits [c*LINES +: LINES] |
| clr_evt | output | MAX_CPUS*LINES | Clear pulses, same packing |
| irq_lvl | output | MAX_CPUS | Per-processor routed-level output |

## Verification
The properties assume that line indices lie below LINES and that the reset is held for at least one clock edge. The spurious-clear property applies only in cycles that have no set strobe and no mask write, so that it isolates the clear path. The stimulus draws line indices only from the valid range. It often narrows them to the lowest eight lines so that repeated sets, spurious clears, same-line collisions and mask writes meet on shared bits. It also addresses the absent processor slot directly.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  // Default geometry of the router.
  localparam int unsigned DEF_LINES    = 64;
  localparam int unsigned DEF_MAX_CPUS = 4;
  localparam int unsigned DEF_NUM_CPUS = 3;

  // One-hot vector of the maximum supported width; callers truncate.
  function automatic logic [255:0] line_onehot(input int unsigned idx);
    logic [255:0] v;
    v = '0;
    v[idx[7:0]] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irq_strobe_dec.sv
module irq_strobe_dec
  import irq_rt_pkg::*;
#(
  parameter int unsigned LINES = DEF_LINES,
  localparam int unsigned LINE_W = $clog2(LINES)
) (
  input  logic              set_vld,
  input  logic [LINE_W-1:0] set_line,
  input  logic              clr_vld,
  input  logic [LINE_W-1:0] clr_line,
  input  logic [LINES-1:0]  raw_q,
  output logic [LINES-1:0]  set_oh,
  output logic [LINES-1:0]  clr_oh
);
  logic same_line;
  logic set_take;
  logic clr_take;
  logic [255:0] set_wide;
  logic [255:0] clr_wide;

  // A clear naming the same line overrides the set in that cycle.
  assign same_line = clr_vld && (clr_line == set_line);
  assign set_take  = set_vld && !same_line;
  // A clear only acts on a line whose raw bit is currently set.
  assign clr_take  = clr_vld && raw_q[clr_line];

  assign set_wide = line_onehot(int'(set_line));
  assign clr_wide = line_onehot(int'(clr_line));

  assign set_oh = set_take ? set_wide[LINES-1:0] : '0;
  assign clr_oh = clr_take ? clr_wide[LINES-1:0] : '0;
endmodule

// File: rtl/irq_raw_reg.sv
module irq_raw_reg
  import irq_rt_pkg::*;
#(
  parameter int unsigned LINES = DEF_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] set_oh,
  input  logic [LINES-1:0] clr_oh,
  output logic [LINES-1:0] raw_q,
  output logic [LINES-1:0] raw_nx
);
  assign raw_nx = (raw_q | set_oh) & ~clr_oh;

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_nx;
  end
endmodule

// File: rtl/irq_cpu_lane.sv
module irq_cpu_lane
  import irq_rt_pkg::*;
#(
  parameter int unsigned LINES = DEF_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [LINES-1:0] wr_data,
  input  logic [LINES-1:0] raw_nx,
  input  logic [LINES-1:0] set_oh,
  output logic [LINES-1:0] mask_q,
  output logic [LINES-1:0] routed_q,
  output logic [LINES-1:0] post_q,
  output logic [LINES-1:0] clr_q,
  output logic             lvl_q
);
  logic [LINES-1:0] mask_nx;
  logic [LINES-1:0] rt_nx;
  logic [LINES-1:0] post_nx;
  logic [LINES-1:0] clr_nx;

  assign mask_nx = wr_hit ? wr_data : mask_q;
  assign rt_nx   = mask_nx & raw_nx;
  // Rising routed bits, plus a repeat post for a fresh device set.
  assign post_nx = (rt_nx & ~routed_q) | (set_oh & mask_nx);
  // Falling routed bits, whichever side caused them.
  assign clr_nx  = routed_q & ~rt_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      routed_q <= '0;
      post_q   <= '0;
      clr_q    <= '0;
      lvl_q    <= 1'b0;
    end else begin
      mask_q   <= mask_nx;
      routed_q <= rt_nx;
      post_q   <= post_nx;
      clr_q    <= clr_nx;
      lvl_q    <= |rt_nx;
    end
  end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_rt_pkg::*;
#(
  parameter int unsigned LINES    = DEF_LINES,
  parameter int unsigned MAX_CPUS = DEF_MAX_CPUS,
  parameter int unsigned NUM_CPUS = DEF_NUM_CPUS,
  localparam int unsigned LINE_W = $clog2(LINES),
  localparam int unsigned CPU_W  = $clog2(MAX_CPUS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dev_set_vld,
  input  logic [LINE_W-1:0]         dev_set_line,
  input  logic                      dev_clr_vld,
  input  logic [LINE_W-1:0]         dev_clr_line,
  input  logic                      msk_wr_en,
  input  logic [CPU_W-1:0]          msk_wr_cpu,
  input  logic [LINES-1:0]          msk_wr_data,
  input  logic [CPU_W-1:0]          rd_cpu,
  output logic [LINES-1:0]          rd_mask,
  output logic [LINES-1:0]          rd_routed,
  output logic [LINES-1:0]          raw_vec,
  output logic [MAX_CPUS*LINES-1:0] post_evt,
  output logic [MAX_CPUS*LINES-1:0] clr_evt,
  output logic [MAX_CPUS-1:0]       irq_lvl
);
  logic [LINES-1:0] set_oh;
  logic [LINES-1:0] clr_oh;
  logic [LINES-1:0] raw_q;
  logic [LINES-1:0] raw_nx;
  logic [LINES-1:0] mask_arr   [MAX_CPUS];
  logic [LINES-1:0] routed_arr [MAX_CPUS];

  irq_strobe_dec #(.LINES(LINES)) u_dec (
    .set_vld  (dev_set_vld),
    .set_line (dev_set_line),
    .clr_vld  (dev_clr_vld),
    .clr_line (dev_clr_line),
    .raw_q    (raw_q),
    .set_oh   (set_oh),
    .clr_oh   (clr_oh)
  );

  irq_raw_reg #(.LINES(LINES)) u_raw (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_oh (set_oh),
    .clr_oh (clr_oh),
    .raw_q  (raw_q),
    .raw_nx (raw_nx)
  );

  assign raw_vec = raw_q;

  for (genvar c = 0; c < MAX_CPUS; c++) begin : g_cpu
    if (c < NUM_CPUS) begin : g_live
      logic hit;
      assign hit = msk_wr_en && (msk_wr_cpu == CPU_W'(c));
      irq_cpu_lane #(.LINES(LINES)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (hit),
        .wr_data  (msk_wr_data),
        .raw_nx   (raw_nx),
        .set_oh   (set_oh),
        .mask_q   (mask_arr[c]),
        .routed_q (routed_arr[c]),
        .post_q   (post_evt[c*LINES +: LINES]),
        .clr_q    (clr_evt[c*LINES +: LINES]),
        .lvl_q    (irq_lvl[c])
      );
    end else begin : g_absent
      assign mask_arr[c]                 = '0;
      assign routed_arr[c]               = '0;
      assign post_evt[c*LINES +: LINES]  = '0;
      assign clr_evt[c*LINES +: LINES]   = '0;
      assign irq_lvl[c]                  = 1'b0;
    end
  end

  assign rd_mask   = mask_arr[rd_cpu];
  assign rd_routed = routed_arr[rd_cpu];
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int unsigned LINES    = 64,
  parameter int unsigned MAX_CPUS = 4,
  parameter int unsigned NUM_CPUS = 3,
  localparam int unsigned LINE_W = $clog2(LINES),
  localparam int unsigned CPU_W  = $clog2(MAX_CPUS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      dev_set_vld,
  input logic [LINE_W-1:0]         dev_set_line,
  input logic                      dev_clr_vld,
  input logic [LINE_W-1:0]         dev_clr_line,
  input logic                      msk_wr_en,
  input logic [CPU_W-1:0]          rd_cpu,
  input logic [LINES-1:0]          rd_mask,
  input logic [LINES-1:0]          rd_routed,
  input logic [LINES-1:0]          raw_vec,
  input logic [MAX_CPUS*LINES-1:0] post_evt,
  input logic [MAX_CPUS*LINES-1:0] clr_evt,
  input logic [MAX_CPUS-1:0]       irq_lvl
);
  assert_route_and_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_routed == (rd_mask & raw_vec));

  assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_set_vld && !(dev_clr_vld && dev_clr_line == dev_set_line))
    |=> raw_vec[$past(dev_set_line)]);

  assert_clear_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_clr_vld && raw_vec[dev_clr_line]) |=> !raw_vec[$past(dev_clr_line)]);

  assert_spurious_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_clr_vld && !dev_set_vld && !msk_wr_en && !raw_vec[dev_clr_line])
    |=> ($stable(raw_vec) && post_evt == '0 && clr_evt == '0));

  assert_level_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lvl[rd_cpu] == (|rd_routed));

  for (genvar c = 0; c < MAX_CPUS; c++) begin : g_c
    assert_post_on_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (post_evt[c*LINES +: LINES] & ~raw_vec) == '0);
    assert_no_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (post_evt[c*LINES +: LINES] & clr_evt[c*LINES +: LINES]) == '0);
    if (c >= NUM_CPUS) begin : g_off
      assert_absent_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        post_evt[c*LINES +: LINES] == '0 && clr_evt[c*LINES +: LINES] == '0
        && !irq_lvl[c]);
    end
  end
endmodule

bind irq_route_top irq_route_chk #(
  .LINES(LINES), .MAX_CPUS(MAX_CPUS), .NUM_CPUS(NUM_CPUS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .dev_set_vld(dev_set_vld), .dev_set_line(dev_set_line),
  .dev_clr_vld(dev_clr_vld), .dev_clr_line(dev_clr_line),
  .msk_wr_en(msk_wr_en), .rd_cpu(rd_cpu),
  .rd_mask(rd_mask), .rd_routed(rd_routed), .raw_vec(raw_vec),
  .post_evt(post_evt), .clr_evt(clr_evt), .irq_lvl(irq_lvl)
);

// File: tb/sim_irq_route_top.sv
module sim_irq_route_top;
  localparam int NL = 64;
  localparam int NC = 4;
  localparam int LIVE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_set_vld = 1'b0, dev_clr_vld = 1'b0, msk_wr_en = 1'b0;
  logic [5:0] dev_set_line = '0, dev_clr_line = '0;
  logic [1:0] msk_wr_cpu = '0, rd_cpu = '0;
  logic [NL-1:0] msk_wr_data = '0;
  logic [NL-1:0] rd_mask, rd_routed, raw_vec;
  logic [NC*NL-1:0] post_evt, clr_evt;
  logic [NC-1:0] irq_lvl;

  int total = 0;
  int bad = 0;
  logic [NL-1:0] m_raw;
  logic [NL-1:0] m_mask [NC];

  always #5 clk = ~clk;

  irq_route_top u0 (
    .clk(clk), .rst_n(rst_n),
    .dev_set_vld(dev_set_vld), .dev_set_line(dev_set_line),
    .dev_clr_vld(dev_clr_vld), .dev_clr_line(dev_clr_line),
    .msk_wr_en(msk_wr_en), .msk_wr_cpu(msk_wr_cpu), .msk_wr_data(msk_wr_data),
    .rd_cpu(rd_cpu), .rd_mask(rd_mask), .rd_routed(rd_routed),
    .raw_vec(raw_vec), .post_evt(post_evt), .clr_evt(clr_evt), .irq_lvl(irq_lvl)
  );

  task automatic chk(input string req, input string what,
                     input logic [NL-1:0] act, input logic [NL-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] bit_of(input int idx);
    return NL'(1) << idx;
  endfunction

  // One cycle of stimulus; expected values follow the requirements.
  task automatic step(input string tag, input bit sv, input int sl,
                      input bit cv, input int cl, input bit wv,
                      input int wc, input logic [NL-1:0] wd, input int rc);
    logic [NL-1:0] nraw, ro, rn, ep, ec, nmask [NC];
    bit set_eff, clr_eff;
    set_eff = sv && !(cv && cl == sl);          // R6
    clr_eff = cv && m_raw[cl];                   // R4 / R5
    nraw = m_raw;
    if (set_eff) nraw |= bit_of(sl);
    if (clr_eff) nraw &= ~bit_of(cl);
    for (int c = 0; c < NC; c++)
      nmask[c] = (wv && wc == c && c < LIVE) ? wd : m_mask[c];  // R10
    dev_set_vld = sv; dev_set_line = 6'(sl);
    dev_clr_vld = cv; dev_clr_line = 6'(cl);
    msk_wr_en = wv; msk_wr_cpu = 2'(wc); msk_wr_data = wd;
    @(posedge clk);
    #2;
    dev_set_vld = 1'b0; dev_clr_vld = 1'b0; msk_wr_en = 1'b0;
    rd_cpu = 2'(rc);
    @(negedge clk);
    chk(tag, "raw", raw_vec, nraw);
    for (int c = 0; c < NC; c++) begin
      ro = m_mask[c] & m_raw;
      rn = nmask[c] & nraw;
      ep = (rn & ~ro) | ((set_eff ? bit_of(sl) : '0) & nmask[c]);
      ec = ro & ~rn;
      if (c >= LIVE) begin ep = '0; ec = '0; end
      chk(tag, $sformatf("post cpu%0d", c), post_evt[c*NL +: NL], ep);
      chk(tag, $sformatf("clear cpu%0d", c), clr_evt[c*NL +: NL], ec);
      chk("R11", $sformatf("lvl cpu%0d", c), NL'(irq_lvl[c]), NL'(|rn));
    end
    chk(tag, "rd_mask", rd_mask, nmask[rc]);
    chk("R2", "rd_routed", rd_routed, nmask[rc] & nraw);
    m_raw = nraw;
    for (int c = 0; c < NC; c++) m_mask[c] = nmask[c];
  endtask

  // Idle cycle used to show that pulses last a single cycle (R9).
  task automatic idle(input int rc);
    step("R9", 0, 0, 0, 0, 0, 0, '0, rc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_raw = '0;
    for (int c = 0; c < NC; c++) m_mask[c] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "raw", raw_vec, '0);
    chk("R1", "post", post_evt[NL-1:0] | post_evt[2*NL-1:NL], '0);
    chk("R1", "clear", clr_evt[NL-1:0] | clr_evt[2*NL-1:NL], '0);
    chk("R1", "lvl", NL'(irq_lvl), '0);
    for (int c = 0; c < NC; c++) begin
      rd_cpu = 2'(c); #1;
      chk("R1", "mask", rd_mask, '0);
    end
    @(negedge clk);

    // Directed corner cases
    step("R7", 0, 0, 0, 0, 1, 0, 64'h0000_0000_0000_0030, 0);
    step("R7", 0, 0, 0, 0, 1, 1, 64'h0000_0000_0000_0020, 1);
    step("R3", 1, 5, 0, 0, 0, 0, '0, 0);
    idle(0);
    step("R3", 1, 5, 0, 0, 0, 0, '0, 1);      // repeat set re-posts
    step("R3", 1, 4, 0, 0, 0, 0, '0, 0);
    step("R7", 0, 0, 0, 0, 1, 1, 64'h0000_0000_0000_0030, 1);  // 0->1 on bit4
    step("R7", 0, 0, 0, 0, 1, 1, 64'h0000_0000_0000_0030, 1);  // no change
    step("R8", 0, 0, 0, 0, 1, 0, 64'h0000_0000_0000_0010, 0);  // drop bit5
    step("R4", 0, 0, 1, 4, 0, 0, '0, 0);
    step("R5", 0, 0, 1, 4, 0, 0, '0, 1);
    step("R5", 0, 0, 1, 60, 0, 0, '0, 0);
    step("R6", 1, 9, 1, 9, 0, 0, '0, 0);       // clear beats set, raw was 0
    step("R3", 1, 9, 0, 0, 1, 2, 64'h0000_0000_0000_0200, 2);
    step("R6", 1, 9, 1, 9, 0, 0, '0, 2);       // clear beats set, raw was 1
    step("R10", 0, 0, 0, 0, 1, 3, 64'hFFFF_FFFF_FFFF_FFFF, 3);
    step("R10", 1, 7, 0, 0, 0, 0, '0, 3);
    idle(3);

    // Constrained random phase
    for (int i = 0; i < 3000; i++) begin
      int sl, cl, wc;
      bit sv, cv, wv;
      logic [NL-1:0] wd;
      sl = ($urandom % 2) ? int'($urandom % 8) : int'($urandom % 64);
      cl = ($urandom % 2) ? int'($urandom % 8) : int'($urandom % 64);
      sv = ($urandom % 3) == 0;
      cv = ($urandom % 3) == 0;
      wv = ($urandom % 5) == 0;
      wc = int'($urandom % 4);
      wd = {$urandom, $urandom};
      if ($urandom % 2) wd[7:0] = 8'($urandom);
      step("R3", sv, sl, cv, cl, wv, wc, wd, int'($urandom % 4));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule